// File: doc/BRIEF.md
# Next Program Counter and Control-Flow Cost Unit

This block sits in the fetch path of a small 8-bit RISC core. For each instruction it works out the next word address the core must fetch. It also reports whether the instruction redirected the flow and how many clock cycles the instruction takes. The core supplies the current program counter and a 4-bit instruction class code. It also supplies the raw offset field, the 16-bit indirect pointer, the return address already popped from the stack, the 8-bit status byte, a bit selector and polarity for conditional branches, the outcome of a skip test, and a flag saying that the following instruction occupies two words. The stack memory and the register file are outside the block.

The block is combinational from its inputs to a single output register. The result for the inputs present at one rising edge is visible after that edge. The program counter width is a parameter and all PC arithmetic wraps modulo 2^PC_W. When PC_W exceeds 16, calls and returns move a wider return address, so each takes one extra cycle. The indirect pointer then fills only the low 16 bits of the PC.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low, pc_next, taken, cycles and set_ie are all zero.
- R2: Class code 0, and any code from 9 to 15, is sequential: pc_next = pc_cur + 1, taken = 0, cycles = 1.
- R3: Code 1 is a relative jump and code 2 is a relative call. pc_next = pc_cur + sext(offset[JMP_OFF_W-1:0]) + 1. The jump costs 2 cycles. The call costs 3 cycles, or 4 when PC_W > 16.
- R4: Code 3 is an indirect jump and code 4 is an indirect call. pc_next takes the pointer value, truncated to PC_W bits or zero-extended above bit 15. The cycle costs are the same as in R3.
- R5: Code 5 is a conditional branch that passes when sreg[bit_sel] equals bit_pol. Status bits are C=0, Z=1, N=2, V=3, S=4 (N xor V), H=5, T=6, I=7. A passing branch gives pc_next = pc_cur + sext(offset[BR_OFF_W-1:0]) + 1 and costs 2 cycles. A failing branch gives pc_cur + 1 and costs 1 cycle. Offset bits above BR_OFF_W-1 have no effect.
- R6: Code 6 is a skip. When skip_cond is 0 it gives pc_cur + 1 in 1 cycle. When skip_cond is 1 it gives pc_cur + 2 in 2 cycles, or pc_cur + 3 in 3 cycles if next_two_word is 1.
- R7: Code 7 is a return and code 8 is an interrupt return. Both give pc_next = ret_addr and cost 4 cycles, or 5 when PC_W > 16. set_ie is 1 only for code 8.
- R8: Every PC sum wraps modulo 2^PC_W.
- R9: taken is 1 for codes 1 to 4, 7 and 8. For code 5 it follows the branch test, and for code 6 it follows skip_cond. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_cur | input | PC_W | Address of the current instruction |
| op_class | input | 4 | Instruction class code |
| offset | input | JMP_OFF_W | Raw signed offset field |
| z_ptr | input | 16 | Indirect target pointer |
| ret_addr | input | PC_W | Return address popped from the stack |
| sreg | input | 8 | Status byte |
| bit_sel | input | 3 | Status bit tested by a branch |
| bit_pol | input | 1 | Branch passes when the bit equals this value |
| skip_cond | input | 1 | Skip test result |
| next_two_word | input | 1 | Following instruction is two words long |
| pc_next | output | PC_W | Next fetch address (registered) |
| taken | output | 1 | Flow was redirected or skipped (registered) |
| cycles | output | 3 | Cycle cost of the instruction (registered) |
| set_ie | output | 1 | Request to set the interrupt enable (registered) |

## Verification
The checker assumes that every input is a stable, known value at each rising edge after reset, since each output is compared against the input values sampled one edge earlier. It also assumes that no output is judged until one full clocked cycle has passed after reset. The stimulus drives all inputs only on falling edges and releases reset on a falling edge. It draws class codes over the full 4-bit range, including the unused codes. It draws random offsets, pointers and status bytes, and adds directed vectors at the wrap boundary and at the extreme negative offsets.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam int CYC_W = 3;

   typedef enum logic [3:0] {
      OP_SEQ    = 4'd0,
      OP_RJMP   = 4'd1,
      OP_RCALL  = 4'd2,
      OP_IJMP   = 4'd3,
      OP_ICALL  = 4'd4,
      OP_BRANCH = 4'd5,
      OP_SKIP   = 4'd6,
      OP_RET    = 4'd7,
      OP_RETI   = 4'd8
   } npc_op_e;

endpackage

// File: rtl/npc_target.sv
module npc_target #(
   parameter int PC_W      = 10,
   parameter int BR_OFF_W  = 7,
   parameter int JMP_OFF_W = 12,
   parameter int PTR_W     = 16
) (
   input  logic [PC_W-1:0]      pc_i,
   input  logic [JMP_OFF_W-1:0] off_i,
   input  logic [PTR_W-1:0]     ptr_i,
   output logic [PC_W-1:0]      step1_o,
   output logic [PC_W-1:0]      step2_o,
   output logic [PC_W-1:0]      step3_o,
   output logic [PC_W-1:0]      rel_o,
   output logic [PC_W-1:0]      br_o,
   output logic [PC_W-1:0]      ind_o
);

   logic [BR_OFF_W-1:0] br_field;
   logic [PC_W-1:0]     jmp_disp;
   logic [PC_W-1:0]     br_disp;

   assign br_field = off_i[BR_OFF_W-1:0];
   assign jmp_disp = PC_W'($signed(off_i));
   assign br_disp  = PC_W'($signed(br_field));

   assign step1_o = pc_i + PC_W'(1);
   assign step2_o = pc_i + PC_W'(2);
   assign step3_o = pc_i + PC_W'(3);
   assign rel_o   = step1_o + jmp_disp;
   assign br_o    = step1_o + br_disp;

   generate
      if (PC_W <= PTR_W) begin : g_ptr_trunc
         assign ind_o = ptr_i[PC_W-1:0];
         if (PC_W < PTR_W) begin : g_ptr_drop
            logic unused_ptr_hi;
            assign unused_ptr_hi = ^ptr_i[PTR_W-1:PC_W];
         end
      end else begin : g_ptr_zext
         assign ind_o = {{(PC_W-PTR_W){1'b0}}, ptr_i};
      end
   endgenerate

endmodule

// File: rtl/npc_cond.sv
module npc_cond #(
   parameter int SREG_W = 8
) (
   input  logic [SREG_W-1:0]         sreg_i,
   input  logic [$clog2(SREG_W)-1:0] sel_i,
   input  logic                      pol_i,
   output logic                      pass_o
);

   localparam int SEL_W = $clog2(SREG_W);

   logic [SREG_W-1:0] hit;

   generate
      for (genvar i = 0; i < SREG_W; i++) begin : g_bit
         assign hit[i] = (sel_i == SEL_W'(i)) && (sreg_i[i] == pol_i);
      end
   endgenerate

   assign pass_o = |hit;

endmodule

// File: rtl/npc_cycles.sv
module npc_cycles
   import npc_pkg::*;
#(
   parameter int PC_W = 10
) (
   input  npc_op_e          op_i,
   input  logic             br_pass_i,
   input  logic             skip_hit_i,
   input  logic             two_word_i,
   output logic [CYC_W-1:0] cyc_o
);

   logic [CYC_W-1:0] call_cyc;
   logic [CYC_W-1:0] ret_cyc;

   generate
      if (PC_W > 16) begin : g_wide_stack
         assign call_cyc = CYC_W'(4);
         assign ret_cyc  = CYC_W'(5);
      end else begin : g_narrow_stack
         assign call_cyc = CYC_W'(3);
         assign ret_cyc  = CYC_W'(4);
      end
   endgenerate

   always_comb begin
      case (op_i)
         OP_RJMP, OP_IJMP:   cyc_o = CYC_W'(2);
         OP_RCALL, OP_ICALL: cyc_o = call_cyc;
         OP_RET, OP_RETI:    cyc_o = ret_cyc;
         OP_BRANCH:          cyc_o = br_pass_i ? CYC_W'(2) : CYC_W'(1);
         OP_SKIP: begin
            if (!skip_hit_i)     cyc_o = CYC_W'(1);
            else if (two_word_i) cyc_o = CYC_W'(3);
            else                 cyc_o = CYC_W'(2);
         end
         default:            cyc_o = CYC_W'(1);
      endcase
   end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int PC_W      = 10,
   parameter int BR_OFF_W  = 7,
   parameter int JMP_OFF_W = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PC_W-1:0]      pc_cur,
   input  logic [3:0]           op_class,
   input  logic [JMP_OFF_W-1:0] offset,
   input  logic [15:0]          z_ptr,
   input  logic [PC_W-1:0]      ret_addr,
   input  logic [7:0]           sreg,
   input  logic [2:0]           bit_sel,
   input  logic                 bit_pol,
   input  logic                 skip_cond,
   input  logic                 next_two_word,
   output logic [PC_W-1:0]      pc_next,
   output logic                 taken,
   output logic [CYC_W-1:0]     cycles,
   output logic                 set_ie
);

   generate
      if (PC_W < 2 || PC_W > 22) begin : g_bad_pc_w
         $error("npc_unit: PC_W must lie in 2..22");
      end
      if (BR_OFF_W < 2 || BR_OFF_W > JMP_OFF_W) begin : g_bad_br_w
         $error("npc_unit: BR_OFF_W must lie in 2..JMP_OFF_W");
      end
      if (JMP_OFF_W < 2 || JMP_OFF_W > 24) begin : g_bad_jmp_w
         $error("npc_unit: JMP_OFF_W must lie in 2..24");
      end
   endgenerate

   npc_op_e          op;
   logic [PC_W-1:0]  step1, step2, step3, rel_tgt, br_tgt, ind_tgt;
   logic             br_pass;
   logic [CYC_W-1:0] cyc_d;
   logic [PC_W-1:0]  pc_d;
   logic             taken_d;
   logic             ie_d;

   assign op = npc_op_e'(op_class);

   npc_target #(
      .PC_W      (PC_W),
      .BR_OFF_W  (BR_OFF_W),
      .JMP_OFF_W (JMP_OFF_W),
      .PTR_W     (16)
   ) u_target (
      .pc_i    (pc_cur),
      .off_i   (offset),
      .ptr_i   (z_ptr),
      .step1_o (step1),
      .step2_o (step2),
      .step3_o (step3),
      .rel_o   (rel_tgt),
      .br_o    (br_tgt),
      .ind_o   (ind_tgt)
   );

   npc_cond #(
      .SREG_W (8)
   ) u_cond (
      .sreg_i (sreg),
      .sel_i  (bit_sel),
      .pol_i  (bit_pol),
      .pass_o (br_pass)
   );

   npc_cycles #(
      .PC_W (PC_W)
   ) u_cycles (
      .op_i       (op),
      .br_pass_i  (br_pass),
      .skip_hit_i (skip_cond),
      .two_word_i (next_two_word),
      .cyc_o      (cyc_d)
   );

   always_comb begin
      pc_d    = step1;
      taken_d = 1'b0;
      ie_d    = 1'b0;
      case (op)
         OP_RJMP, OP_RCALL: begin
            pc_d    = rel_tgt;
            taken_d = 1'b1;
         end
         OP_IJMP, OP_ICALL: begin
            pc_d    = ind_tgt;
            taken_d = 1'b1;
         end
         OP_BRANCH: begin
            pc_d    = br_pass ? br_tgt : step1;
            taken_d = br_pass;
         end
         OP_SKIP: begin
            if (skip_cond) pc_d = next_two_word ? step3 : step2;
            taken_d = skip_cond;
         end
         OP_RET: begin
            pc_d    = ret_addr;
            taken_d = 1'b1;
         end
         OP_RETI: begin
            pc_d    = ret_addr;
            taken_d = 1'b1;
            ie_d    = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_next <= '0;
         taken   <= 1'b0;
         cycles  <= '0;
         set_ie  <= 1'b0;
      end else begin
         pc_next <= pc_d;
         taken   <= taken_d;
         cycles  <= cyc_d;
         set_ie  <= ie_d;
      end
   end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int PC_W      = 10,
   parameter int BR_OFF_W  = 7,
   parameter int JMP_OFF_W = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [PC_W-1:0]      pc_cur,
   input logic [3:0]           op_class,
   input logic [15:0]          z_ptr,
   input logic                 skip_cond,
   input logic                 next_two_word,
   input logic [PC_W-1:0]      pc_next,
   input logic                 taken,
   input logic [2:0]           cycles,
   input logic                 set_ie
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(op_class) == 4'd0 |->
         pc_next == PC_W'($past(pc_cur) + PC_W'(1)) && cycles == 3'd1 && !taken);

   p_ind_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed && ($past(op_class) == 4'd3 || $past(op_class) == 4'd4) |->
         pc_next == PC_W'($past(z_ptr)) && taken);

   p_branch_cost_r5: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(op_class) == 4'd5 |->
         cycles == (taken ? 3'd2 : 3'd1));

   p_skip_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(op_class) == 4'd6 && !$past(skip_cond) |->
         cycles == 3'd1 && !taken && pc_next == PC_W'($past(pc_cur) + PC_W'(1)));

   p_skip_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(op_class) == 4'd6 && $past(skip_cond) |->
         taken && cycles == ($past(next_two_word) ? 3'd3 : 3'd2));

   p_ie_only_reti_r7: assert property (@(posedge clk) disable iff (!rst_n)
      armed && set_ie |-> $past(op_class) == 4'd8);

endmodule

bind npc_unit npc_unit_chk #(
   .PC_W      (PC_W),
   .BR_OFF_W  (BR_OFF_W),
   .JMP_OFF_W (JMP_OFF_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pc_cur        (pc_cur),
   .op_class      (op_class),
   .z_ptr         (z_ptr),
   .skip_cond     (skip_cond),
   .next_two_word (next_two_word),
   .pc_next       (pc_next),
   .taken         (taken),
   .cycles        (cycles),
   .set_ie        (set_ie)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;

   localparam int PC_W      = 10;
   localparam int BR_OFF_W  = 7;
   localparam int JMP_OFF_W = 12;
   localparam int MASK      = (1 << PC_W) - 1;
   localparam int CALL_CYC  = (PC_W > 16) ? 4 : 3;
   localparam int RET_CYC   = (PC_W > 16) ? 5 : 4;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [PC_W-1:0]      pc_cur = '0;
   logic [3:0]           op_class = '0;
   logic [JMP_OFF_W-1:0] offset = '0;
   logic [15:0]          z_ptr = '0;
   logic [PC_W-1:0]      ret_addr = '0;
   logic [7:0]           sreg = '0;
   logic [2:0]           bit_sel = '0;
   logic                 bit_pol = 1'b0;
   logic                 skip_cond = 1'b0;
   logic                 next_two_word = 1'b0;
   logic [PC_W-1:0]      pc_next;
   logic                 taken;
   logic [2:0]           cycles;
   logic                 set_ie;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   always #4 clk = ~clk;

   npc_unit #(
      .PC_W      (PC_W),
      .BR_OFF_W  (BR_OFF_W),
      .JMP_OFF_W (JMP_OFF_W)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .pc_cur        (pc_cur),
      .op_class      (op_class),
      .offset        (offset),
      .z_ptr         (z_ptr),
      .ret_addr      (ret_addr),
      .sreg          (sreg),
      .bit_sel       (bit_sel),
      .bit_pol       (bit_pol),
      .skip_cond     (skip_cond),
      .next_two_word (next_two_word),
      .pc_next       (pc_next),
      .taken         (taken),
      .cycles        (cycles),
      .set_ie        (set_ie)
   );

   function automatic int sext(int v, int w);
      int m = v & ((1 << w) - 1);
      if (m & (1 << (w - 1))) return m - (1 << w);
      return m;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Reference model built from the requirements
   task automatic expect_of(output int e_pc, output int e_tk, output int e_cy,
                            output int e_ie, output string tag);
      int pc = int'(pc_cur);
      e_pc = (pc + 1) & MASK; e_tk = 0; e_cy = 1; e_ie = 0; tag = "R2";
      case (int'(op_class))
         1, 2: begin
            tag  = "R3"; e_tk = 1;
            e_pc = (pc + sext(int'(offset), JMP_OFF_W) + 1) & MASK;
            e_cy = (op_class == 4'd1) ? 2 : CALL_CYC;
         end
         3, 4: begin
            tag  = "R4"; e_tk = 1;
            e_pc = int'(z_ptr) & MASK;
            e_cy = (op_class == 4'd3) ? 2 : CALL_CYC;
         end
         5: begin
            tag = "R5";
            if (sreg[bit_sel] == bit_pol) begin
               e_tk = 1; e_cy = 2;
               e_pc = (pc + sext(int'(offset), BR_OFF_W) + 1) & MASK;
            end
         end
         6: begin
            tag = "R6";
            if (skip_cond) begin
               e_tk = 1;
               e_cy = next_two_word ? 3 : 2;
               e_pc = (pc + e_cy) & MASK;
            end
         end
         7, 8: begin
            tag  = "R7"; e_tk = 1; e_cy = RET_CYC;
            e_pc = int'(ret_addr);
            e_ie = (op_class == 4'd8) ? 1 : 0;
         end
         default: ;
      endcase
   endtask

   // Called at a falling edge with inputs already set; checks after next edge.
   task automatic step(string tag_override);
      int e_pc, e_tk, e_cy, e_ie;
      string tag;
      expect_of(e_pc, e_tk, e_cy, e_ie, tag);
      if (tag_override != "") tag = tag_override;
      @(posedge clk);
      @(negedge clk);
      chk(tag,  "pc_next", int'(pc_next), e_pc);
      chk("R9", "taken",   int'(taken),   e_tk);
      chk(tag,  "cycles",  int'(cycles),  e_cy);
      chk("R7", "set_ie",  int'(set_ie),  e_ie);
   endtask

   task automatic set_in(int op, int pc, int off, int z, int ra, int sr,
                         int bs, int bp, int sc, int tw);
      op_class      = 4'(op);
      pc_cur        = PC_W'(pc);
      offset        = JMP_OFF_W'(off);
      z_ptr         = 16'(z);
      ret_addr      = PC_W'(ra);
      sreg          = 8'(sr);
      bit_sel       = 3'(bs);
      bit_pol       = 1'(bp);
      skip_cond     = 1'(sc);
      next_two_word = 1'(tw);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL R1 watchdog actual=timeout expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      set_in(1, 100, 5, 3, 7, 8'hFF, 0, 1, 1, 1);
      repeat (3) @(negedge clk);
      // R1: reset holds all outputs low even with active inputs
      chk("R1", "pc_next reset", int'(pc_next), 0);
      chk("R1", "taken reset",   int'(taken),   0);
      chk("R1", "cycles reset",  int'(cycles),  0);
      chk("R1", "set_ie reset",  int'(set_ie),  0);
      rst_n = 1'b1;

      // R2 sequential and unused class codes
      set_in(0, 37, 0, 0, 0, 0, 0, 0, 0, 0);           step("R2");
      set_in(12, 200, 55, 9, 9, 8'hFF, 1, 1, 1, 1);    step("R2");
      // R8 wrap of the sequential step at the top of memory
      set_in(0, MASK, 0, 0, 0, 0, 0, 0, 0, 0);         step("R8");
      // R3 relative jump with k = -1 lands back on itself; most negative k
      set_in(1, 300, -1, 0, 0, 0, 0, 0, 0, 0);         step("R3");
      set_in(2, 5, -2048, 0, 0, 0, 0, 0, 0, 0);        step("R8");
      // R4 pointer above PC range is truncated
      set_in(4, 0, 0, 16'hFFF3, 0, 0, 0, 0, 0, 0);     step("R4");
      // R5 signed greater-or-equal: N=1,V=1,S=0 tested on bit 4 clear
      set_in(5, 10, 3, 0, 0, 8'b0000_1100, 4, 0, 0, 0); step("R5");
      // R5 lower: C set, with high offset bits that must have no effect
      set_in(5, 10, 12'hF80 | 12'h40, 0, 0, 8'h01, 0, 1, 0, 0); step("R5");
      // R5 failing test falls through
      set_in(5, 10, 12'h3F, 0, 0, 8'h01, 0, 0, 0, 0);  step("R5");
      // R6 skip cases, including two-word wrap
      set_in(6, 20, 0, 0, 0, 0, 0, 0, 0, 1);           step("R6");
      set_in(6, 20, 0, 0, 0, 0, 0, 0, 1, 0);           step("R6");
      set_in(6, MASK - 1, 0, 0, 0, 0, 0, 0, 1, 1);     step("R6");
      // R7 return versus interrupt return
      set_in(7, 1, 0, 0, 444, 0, 0, 0, 0, 0);          step("R7");
      set_in(8, 1, 0, 0, 123, 0, 0, 0, 0, 0);          step("R7");

      // Constrained random mix
      for (int i = 0; i < 3000; i++) begin
         int op;
         op = int'($urandom % 10);
         if (op == 9) op = 9 + int'($urandom % 7);
         set_in(op, int'($urandom), int'($urandom), int'($urandom), int'($urandom),
                int'($urandom), int'($urandom), int'($urandom), int'($urandom),
                int'($urandom));
         step("");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule